// File: doc/BRIEF.md
# Register Window Decoder with Access Serializer

This block sits behind a 4 KiB memory-mapped register window and splits it into three sub-regions. The first is a bank of 32 legacy byte-wide I/O ports. Any access wider than a byte is broken into byte transactions on a downstream byte-port bus. The second is an indexed file of 16-bit display-extension registers. Each register access becomes two transactions on an index/data bus: an index write, then a data read or write. The third is a small local bank of two 32-bit words, which holds a framebuffer byte-order flag.

The upstream side is a single-outstanding request/ready bus. A request carries an address, a write flag, a byte size of 1, 2 or 4, and write data. The requester holds its request until `req_ready` is high at a clock edge. Read data is valid in that same cycle.

Local and unmapped accesses finish in the cycle they are presented. Serialized accesses are handled by a state machine with five states:
- `ST_IDLE`: accepts a request. Idle→port on a port-bank hit, idle→index on an extension hit.
- `ST_PORT_BEAT`: holds one byte strobe until it is acknowledged. Port→port for the next byte, port→done after the last byte.
- `ST_IDX_BEAT`: drives the index write. Index→data on acknowledge.
- `ST_DATA_BEAT`: drives the data access. Data→index for a second register, data→done after the last register.
- `ST_DONE`: presents the assembled read data with ready. Done→idle unconditionally.

Top module: `mmio_window_decoder`

## Requirements
- R1: A 1-byte write at window offset 0x400+k (k < 32) issues exactly one byte write to port 0x3C0+k, carrying `req_wdata[7:0]`.
- R2: A 2-byte or 4-byte write to the port bank issues one byte write per byte, in ascending port order. The lowest port receives `req_wdata[7:0]` and each following port receives the next byte up.
- R3: A port-bank read of N bytes performs N byte reads in ascending port order. The byte read from the lowest port appears in `rsp_rdata[7:0]`, the next in bits 15:8, and so on.
- R4: An access at offset 0x500+2i (i < 11) is handled as follows. First comes an index beat (`ix_sel`=0, `ix_we`=1, `ix_wdata`=i). Then comes a data beat (`ix_sel`=1) that carries the request's direction and its low 16 data bits; read data is returned in `rsp_rdata[15:0]`. A 4-byte access repeats the pair for register i+1, using data bits 31:16.
- R5: A 4-byte read at offset 0x600 returns 8. A local-bank access whose size is not 4 returns zero and has no effect.
- R6: A 4-byte read at offset 0x604 returns 0xBEBEBEBE while the byte-order flag is set and 0x1E1E1E1E while it is clear. Reset clears the flag, and `fb_big_endian` reflects it.
- R7: A 4-byte write at 0x604 sets the flag only for 0xBEBEBEBE and clears it only for 0x1E1E1E1E. Any other value, and any write at 0x600, leaves the flag unchanged.
- R8: An access outside all sub-regions, including one that runs past a sub-region's end, returns zero. It raises `req_ready` in the cycle it is presented and pulses no downstream strobe.
- R9: Each downstream strobe and its fields stay stable until acknowledged. `req_ready` stays low until the last beat is acknowledged and rises in the following cycle.
- R10: `rev_id` is 2 when the local bank is enabled and 0 when it is not. With the bank disabled, offset 0x600 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Upstream request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, little-endian lanes |
| req_ready | output | 1 | Request completes at this edge |
| rsp_rdata | output | 32 | Read data, valid with req_ready |
| bp_stb | output | 1 | Byte-port beat request |
| bp_we | output | 1 | Byte-port beat is a write |
| bp_port | output | 10 | Downstream port number |
| bp_wdata | output | 8 | Byte-port write data |
| bp_rdata | input | 8 | Byte-port read data, valid with ack |
| bp_ack | input | 1 | Byte-port beat accepted |
| ix_stb | output | 1 | Index/data beat request |
| ix_sel | output | 1 | 0 = index port, 1 = data port |
| ix_we | output | 1 | Index/data beat is a write |
| ix_wdata | output | 16 | Index value or register write data |
| ix_rdata | input | 16 | Register read data, valid with ack |
| ix_ack | input | 1 | Index/data beat accepted |
| fb_big_endian | output | 1 | Framebuffer byte-order flag |
| rev_id | output | 8 | Revision identifier |

## Verification
The bench builds two instances: `uut` with the default parameters (local bank enabled) and a second one with the local bank disabled. The default build makes every serialization path reachable: all three port-access widths, single- and double-register extension accesses, and the magic-word flag transitions. The disabled build shows the revision change and that offset 0x600 falls through to the zero-read path. The downstream responders acknowledge one cycle after each strobe appears, so each beat takes exactly two cycles and ready latency can be checked as an exact count.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_PORT,
        RGN_EXT,
        RGN_LOCAL
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PORT_BEAT,
        ST_IDX_BEAT,
        ST_DATA_BEAT,
        ST_DONE
    } seq_state_e;

    localparam int          LOC_BYTES    = 8;
    localparam logic [31:0] MAGIC_BIG    = 32'hBEBE_BEBE;
    localparam logic [31:0] MAGIC_LITTLE = 32'h1E1E_1E1E;

endpackage

// File: rtl/mwd_region_decode.sv
module mwd_region_decode
    import mwd_pkg::*;
#(
    parameter int AW        = 12,
    parameter int PORT_BASE = 'h400,
    parameter int PORT_SPAN = 32,
    parameter int EXT_BASE  = 'h500,
    parameter int EXT_REGS  = 11,
    parameter int LOC_BASE  = 'h600,
    parameter bit LOC_EN    = 1'b1
) (
    input  logic [AW-1:0] addr,
    input  logic [2:0]    size,
    output region_e       region,
    output logic [AW-1:0] offset
);

    localparam int PORT_END = PORT_BASE + PORT_SPAN;
    localparam int EXT_END  = EXT_BASE + 2 * EXT_REGS;
    localparam int LOC_END  = LOC_BASE + LOC_BYTES;

    logic          size_ok;
    logic [AW:0]   a_lo;
    logic [AW:0]   a_hi;
    logic          in_port;
    logic          in_ext;
    logic          in_loc;

    assign size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
    assign a_lo    = {1'b0, addr};
    assign a_hi    = a_lo + (AW+1)'(size);

    assign in_port = size_ok && (a_lo >= (AW+1)'(PORT_BASE)) && (a_hi <= (AW+1)'(PORT_END));
    assign in_ext  = size_ok && (a_lo >= (AW+1)'(EXT_BASE))  && (a_hi <= (AW+1)'(EXT_END));

    generate
        if (LOC_EN) begin : g_loc_on
            assign in_loc = (size == 3'd4) && (a_lo >= (AW+1)'(LOC_BASE)) && (a_hi <= (AW+1)'(LOC_END));
        end else begin : g_loc_off
            assign in_loc = 1'b0;
        end
    endgenerate

    always_comb begin
        region = RGN_NONE;
        offset = '0;
        if (in_port) begin
            region = RGN_PORT;
            offset = addr - AW'(PORT_BASE);
        end else if (in_ext) begin
            region = RGN_EXT;
            offset = addr - AW'(EXT_BASE);
        end else if (in_loc) begin
            region = RGN_LOCAL;
            offset = addr - AW'(LOC_BASE);
        end
    end

endmodule

// File: rtl/mwd_local_bank.sv
module mwd_local_bank
    import mwd_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] off,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic          big_endian
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            big_endian <= 1'b0;
        end else if (wr_en && off == AW'(4)) begin
            if (wdata == MAGIC_BIG) begin
                big_endian <= 1'b1;
            end else if (wdata == MAGIC_LITTLE) begin
                big_endian <= 1'b0;
            end
        end
    end

    always_comb begin
        case (off)
            AW'(0):  rdata = 32'(LOC_BYTES);
            AW'(4):  rdata = big_endian ? MAGIC_BIG : MAGIC_LITTLE;
            default: rdata = 32'h0;
        endcase
    end

    // R7
    flag_magic_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (big_endian != $past(big_endian)) |->
            $past(wr_en && off == AW'(4) && (wdata == MAGIC_BIG || wdata == MAGIC_LITTLE)));

endmodule

// File: rtl/mwd_sequencer.sv
module mwd_sequencer
    import mwd_pkg::*;
#(
    parameter int AW       = 12,
    parameter int PW       = 10,
    parameter int PORT_MAP = 'h3C0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  region_e       region,
    input  logic          write,
    input  logic [AW-1:0] offset,
    input  logic [2:0]    size,
    input  logic [31:0]   wdata,
    output logic          idle,
    output logic          done,
    output logic [31:0]   rdata,
    output logic          bp_stb,
    output logic          bp_we,
    output logic [PW-1:0] bp_port,
    output logic [7:0]    bp_wdata,
    input  logic [7:0]    bp_rdata,
    input  logic          bp_ack,
    output logic          ix_stb,
    output logic          ix_sel,
    output logic          ix_we,
    output logic [15:0]   ix_wdata,
    input  logic [15:0]   ix_rdata,
    input  logic          ix_ack
);

    seq_state_e    state, nstate;
    logic [1:0]    beat;
    logic [1:0]    last_beat;
    logic [AW-1:0] cap_off;
    logic          cap_we;
    logic [31:0]   cap_wdata;
    logic [31:0]   asm_data;
    logic          beat_end;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (start) nstate = (region == RGN_PORT) ? ST_PORT_BEAT : ST_IDX_BEAT;
            end
            ST_PORT_BEAT: begin
                if (bp_ack && beat == last_beat) nstate = ST_DONE;
            end
            ST_IDX_BEAT: begin
                if (ix_ack) nstate = ST_DATA_BEAT;
            end
            ST_DATA_BEAT: begin
                if (ix_ack) nstate = (beat == last_beat) ? ST_DONE : ST_IDX_BEAT;
            end
            ST_DONE: nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    assign beat_end = (state == ST_PORT_BEAT && bp_ack) || (state == ST_DATA_BEAT && ix_ack);

    // captured request and beat bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat      <= '0;
            last_beat <= '0;
            cap_off   <= '0;
            cap_we    <= 1'b0;
            cap_wdata <= '0;
            asm_data  <= '0;
        end else if (state == ST_IDLE && start) begin
            beat      <= '0;
            cap_off   <= offset;
            cap_we    <= write;
            cap_wdata <= wdata;
            asm_data  <= '0;
            if (region == RGN_PORT) last_beat <= 2'(size - 3'd1);
            else                    last_beat <= (size == 3'd4) ? 2'd1 : 2'd0;
        end else begin
            if (state == ST_PORT_BEAT && bp_ack && !cap_we)
                asm_data[{beat, 3'b000} +: 8] <= bp_rdata;
            if (state == ST_DATA_BEAT && ix_ack && !cap_we)
                asm_data[{beat[0], 4'b0000} +: 16] <= ix_rdata;
            if (beat_end && beat != last_beat)
                beat <= beat + 2'd1;
        end
    end

    // outputs
    always_comb begin
        idle     = (state == ST_IDLE);
        done     = (state == ST_DONE);
        rdata    = asm_data;
        bp_stb   = (state == ST_PORT_BEAT);
        bp_we    = cap_we;
        bp_port  = PW'(PORT_MAP) + PW'(cap_off) + PW'(beat);
        bp_wdata = cap_wdata[{beat, 3'b000} +: 8];
        ix_stb   = (state == ST_IDX_BEAT) || (state == ST_DATA_BEAT);
        ix_sel   = (state == ST_DATA_BEAT);
        ix_we    = (state == ST_IDX_BEAT) || cap_we;
        if (state == ST_IDX_BEAT) ix_wdata = 16'(cap_off >> 1) + 16'(beat);
        else                      ix_wdata = beat[0] ? cap_wdata[31:16] : cap_wdata[15:0];
    end

    // R9
    port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_stb && !bp_ack) |=> (bp_stb && $stable(bp_port) && $stable(bp_wdata)));

    // R2
    port_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_stb && bp_ack && beat != last_beat) |=> (bp_stb && bp_port == $past(bp_port) + PW'(1)));

    // R4
    index_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ix_stb) |-> !ix_sel);

    // R9
    ix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ix_stb && !ix_ack) |=> (ix_stb && $stable(ix_sel) && $stable(ix_wdata)));

endmodule

// File: rtl/mmio_window_decoder.sv
module mmio_window_decoder
    import mwd_pkg::*;
#(
    parameter int AW        = 12,
    parameter int PW        = 10,
    parameter int PORT_BASE = 'h400,
    parameter int PORT_SPAN = 32,
    parameter int PORT_MAP  = 'h3C0,
    parameter int EXT_BASE  = 'h500,
    parameter int EXT_REGS  = 11,
    parameter int LOC_BASE  = 'h600,
    parameter bit LOC_EN    = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [2:0]    req_size,
    input  logic [31:0]   req_wdata,
    output logic          req_ready,
    output logic [31:0]   rsp_rdata,
    output logic          bp_stb,
    output logic          bp_we,
    output logic [PW-1:0] bp_port,
    output logic [7:0]    bp_wdata,
    input  logic [7:0]    bp_rdata,
    input  logic          bp_ack,
    output logic          ix_stb,
    output logic          ix_sel,
    output logic          ix_we,
    output logic [15:0]   ix_wdata,
    input  logic [15:0]   ix_rdata,
    input  logic          ix_ack,
    output logic          fb_big_endian,
    output logic [7:0]    rev_id
);

    localparam logic [7:0] REV_VALUE = LOC_EN ? 8'd2 : 8'd0;

    region_e       region;
    logic [AW-1:0] offset;
    logic          seq_idle;
    logic          seq_done;
    logic [31:0]   seq_rdata;
    logic [31:0]   loc_rdata;
    logic          quick;
    logic          start;
    logic          loc_wr;

    mwd_region_decode #(
        .AW(AW), .PORT_BASE(PORT_BASE), .PORT_SPAN(PORT_SPAN),
        .EXT_BASE(EXT_BASE), .EXT_REGS(EXT_REGS),
        .LOC_BASE(LOC_BASE), .LOC_EN(LOC_EN)
    ) u_decode (
        .addr(req_addr), .size(req_size), .region(region), .offset(offset)
    );

    assign quick  = (region == RGN_NONE) || (region == RGN_LOCAL);
    assign start  = seq_idle && req_valid && !quick;
    assign loc_wr = seq_idle && req_valid && req_write && (region == RGN_LOCAL);

    mwd_local_bank #(.AW(AW)) u_local (
        .clk(clk), .rst_n(rst_n), .wr_en(loc_wr), .off(offset),
        .wdata(req_wdata), .rdata(loc_rdata), .big_endian(fb_big_endian)
    );

    mwd_sequencer #(.AW(AW), .PW(PW), .PORT_MAP(PORT_MAP)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .region(region),
        .write(req_write), .offset(offset), .size(req_size), .wdata(req_wdata),
        .idle(seq_idle), .done(seq_done), .rdata(seq_rdata),
        .bp_stb(bp_stb), .bp_we(bp_we), .bp_port(bp_port), .bp_wdata(bp_wdata),
        .bp_rdata(bp_rdata), .bp_ack(bp_ack),
        .ix_stb(ix_stb), .ix_sel(ix_sel), .ix_we(ix_we), .ix_wdata(ix_wdata),
        .ix_rdata(ix_rdata), .ix_ack(ix_ack)
    );

    always_comb begin
        req_ready = seq_done || (seq_idle && req_valid && quick);
        if (seq_done)                 rsp_rdata = seq_rdata;
        else if (region == RGN_LOCAL) rsp_rdata = loc_rdata;
        else                          rsp_rdata = 32'h0;
    end

    assign rev_id = REV_VALUE;

    // R9
    no_ready_mid_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_stb || ix_stb) |-> !req_ready);

    // R8
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bp_stb && ix_stb));

endmodule

// File: tb/mmio_window_decoder_test.sv
`timescale 1ns/1ps
module mmio_window_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_valid2 = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [2:0]  req_size = 3'd1;
    logic [31:0] req_wdata = '0;
    logic        req_ready, req_ready2;
    logic [31:0] rsp_rdata, rsp_rdata2;
    logic        bp_stb, bp_we, bp_ack = 1'b0;
    logic [9:0]  bp_port;
    logic [7:0]  bp_wdata, bp_rdata = '0;
    logic        ix_stb, ix_sel, ix_we, ix_ack = 1'b0;
    logic [15:0] ix_wdata, ix_rdata = '0;
    logic        fb_big_endian, fb2;
    logic [7:0]  rev_id, rev2;
    logic        n_bp_stb, n_bp_we, n_ix_stb, n_ix_sel, n_ix_we;
    logic [9:0]  n_bp_port;
    logic [7:0]  n_bp_wdata;
    logic [15:0] n_ix_wdata;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    int          bp_n = 0, ix_n = 0;
    logic [9:0]  lg_port [16];
    logic [7:0]  lg_bdat [16];
    logic        lg_bwe  [16];
    logic        lg_sel  [16];
    logic        lg_iwe  [16];
    logic [15:0] lg_idat [16];
    logic [15:0] cur_idx = '0;

    always #2.5 clk = ~clk;

    mmio_window_decoder uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .bp_stb(bp_stb), .bp_we(bp_we), .bp_port(bp_port), .bp_wdata(bp_wdata),
        .bp_rdata(bp_rdata), .bp_ack(bp_ack),
        .ix_stb(ix_stb), .ix_sel(ix_sel), .ix_we(ix_we), .ix_wdata(ix_wdata),
        .ix_rdata(ix_rdata), .ix_ack(ix_ack),
        .fb_big_endian(fb_big_endian), .rev_id(rev_id)
    );

    mmio_window_decoder #(.LOC_EN(1'b0)) uut_noloc (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid2), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_ready(req_ready2), .rsp_rdata(rsp_rdata2),
        .bp_stb(n_bp_stb), .bp_we(n_bp_we), .bp_port(n_bp_port), .bp_wdata(n_bp_wdata),
        .bp_rdata(8'h00), .bp_ack(1'b0),
        .ix_stb(n_ix_stb), .ix_sel(n_ix_sel), .ix_we(n_ix_we), .ix_wdata(n_ix_wdata),
        .ix_rdata(16'h0000), .ix_ack(1'b0),
        .fb_big_endian(fb2), .rev_id(rev2)
    );

    function automatic logic [7:0] port_val(input logic [9:0] p);
        return p[7:0] ^ 8'h5A;
    endfunction

    // downstream responders: acknowledge one cycle after a strobe appears
    always @(negedge clk) begin
        if (bp_stb && !bp_ack) begin
            bp_ack   = 1'b1;
            bp_rdata = port_val(bp_port);
            if (bp_n < 16) begin
                lg_port[bp_n] = bp_port; lg_bdat[bp_n] = bp_wdata; lg_bwe[bp_n] = bp_we;
            end
            bp_n++;
        end else begin
            bp_ack = 1'b0;
        end
        if (ix_stb && !ix_ack) begin
            ix_ack = 1'b1;
            if (!ix_sel) cur_idx = ix_wdata;
            ix_rdata = 16'hC000 | cur_idx;
            if (ix_n < 16) begin
                lg_sel[ix_n] = ix_sel; lg_iwe[ix_n] = ix_we; lg_idat[ix_n] = ix_wdata;
            end
            ix_n++;
        end else begin
            ix_ack = 1'b0;
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        bp_n = 0; ix_n = 0;
    endtask

    task automatic access(input logic wr, input logic [11:0] a, input logic [2:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd, output int waits);
        @(negedge clk);
        req_write = wr; req_addr = a; req_size = sz; req_wdata = wd; req_valid = 1'b1;
        waits = 0;
        #1;
        while (!req_ready && waits < 200) begin
            @(negedge clk);
            #1;
            waits++;
        end
        rd = rsp_rdata;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R6 reset flag", 32'(fb_big_endian), 32'd0);
        check("R9 reset ready", 32'(req_ready), 32'd0);
        check("R8 reset strobes", {30'd0, bp_stb, ix_stb}, 32'd0);
        check("R10 rev enabled", 32'(rev_id), 32'd2);
    endtask

    task automatic t_port_writes();
        logic [31:0] rd; int w;
        clear_logs();
        access(1'b1, 12'h405, 3'd1, 32'h0000_0077, rd, w);
        check("R1 beat count", 32'(bp_n), 32'd1);
        check("R1 port", 32'(lg_port[0]), 32'h3C5);
        check("R1 data", {23'd0, lg_bwe[0], lg_bdat[0]}, 32'h177);
        check("R9 one-beat latency", 32'(w), 32'd2);
        clear_logs();
        access(1'b1, 12'h414, 3'd2, 32'h0000_1234, rd, w);
        check("R2 word beats", 32'(bp_n), 32'd2);
        check("R2 low first", {12'd0, 2'd0, lg_port[0], lg_bdat[0]}, {12'd0, 2'd0, 10'h3D4, 8'h34});
        check("R2 high second", {12'd0, 2'd0, lg_port[1], lg_bdat[1]}, {12'd0, 2'd0, 10'h3D5, 8'h12});
        clear_logs();
        access(1'b1, 12'h400, 3'd4, 32'hDDCC_BBAA, rd, w);
        check("R2 dword beats", 32'(bp_n), 32'd4);
        for (int i = 0; i < 4; i++)
            check("R2 dword order", {14'd0, lg_port[i], lg_bdat[i]},
                  {14'd0, 10'h3C0 + 10'(i), 8'hAA + 8'(i * 8'h11)});
        check("R9 four-beat latency", 32'(w), 32'd8);
    endtask

    task automatic t_port_reads();
        logic [31:0] rd; int w;
        clear_logs();
        access(1'b0, 12'h410, 3'd2, 32'h0, rd, w);
        check("R3 word read", rd, {16'd0, port_val(10'h3D1), port_val(10'h3D0)});
        check("R9 two-beat latency", 32'(w), 32'd4);
        access(1'b0, 12'h41F, 3'd1, 32'h0, rd, w);
        check("R3 byte read", rd, {24'd0, port_val(10'h3DF)});
        access(1'b0, 12'h41C, 3'd4, 32'h0, rd, w);
        check("R3 dword read", rd, {port_val(10'h3DF), port_val(10'h3DE),
                                    port_val(10'h3DD), port_val(10'h3DC)});
    endtask

    task automatic t_ext();
        logic [31:0] rd; int w;
        clear_logs();
        access(1'b1, 12'h506, 3'd2, 32'h0000_BEEF, rd, w);
        check("R4 write beats", 32'(ix_n), 32'd2);
        check("R4 index beat", {14'd0, lg_sel[0], lg_iwe[0], lg_idat[0]}, {14'd0, 2'b01, 16'd3});
        check("R4 data beat", {14'd0, lg_sel[1], lg_iwe[1], lg_idat[1]}, {14'd0, 2'b11, 16'hBEEF});
        clear_logs();
        access(1'b0, 12'h510, 3'd4, 32'h0, rd, w);
        check("R4 dword read", rd, 32'hC009_C008);
        check("R4 dword beats", 32'(ix_n), 32'd4);
        check("R4 second index", {15'd0, lg_sel[2], lg_idat[2]}, {15'd0, 1'b0, 16'd9});
        check("R4 data is read", 32'(lg_iwe[3]), 32'd0);
        check("R9 ext latency", 32'(w), 32'd8);
    endtask

    task automatic t_local();
        logic [31:0] rd; int w;
        clear_logs();
        access(1'b0, 12'h600, 3'd4, 32'h0, rd, w);
        check("R5 size word", rd, 32'd8);
        check("R8 local same cycle", 32'(w), 32'd0);
        access(1'b0, 12'h600, 3'd2, 32'h0, rd, w);
        check("R5 narrow read zero", rd, 32'd0);
        access(1'b0, 12'h604, 3'd4, 32'h0, rd, w);
        check("R6 little magic", rd, 32'h1E1E_1E1E);
        access(1'b1, 12'h604, 3'd4, 32'h1234_5678, rd, w);
        check("R7 non-magic ignored", 32'(fb_big_endian), 32'd0);
        access(1'b1, 12'h604, 3'd2, 32'hBEBE_BEBE, rd, w);
        check("R5 narrow write ignored", 32'(fb_big_endian), 32'd0);
        access(1'b1, 12'h604, 3'd4, 32'hBEBE_BEBE, rd, w);
        check("R7 set flag", 32'(fb_big_endian), 32'd1);
        access(1'b0, 12'h604, 3'd4, 32'h0, rd, w);
        check("R6 big magic", rd, 32'hBEBE_BEBE);
        access(1'b1, 12'h600, 3'd4, 32'h1E1E_1E1E, rd, w);
        check("R7 offset0 write ignored", 32'(fb_big_endian), 32'd1);
        access(1'b1, 12'h604, 3'd4, 32'h1E1E_1E1F, rd, w);
        check("R7 near-magic ignored", 32'(fb_big_endian), 32'd1);
        access(1'b1, 12'h604, 3'd4, 32'h1E1E_1E1E, rd, w);
        check("R7 clear flag", 32'(fb_big_endian), 32'd0);
        check("R8 local no strobes", 32'(bp_n + ix_n), 32'd0);
    endtask

    task automatic t_unmapped();
        logic [31:0] rd; int w;
        clear_logs();
        access(1'b0, 12'h300, 3'd4, 32'h0, rd, w);
        check("R8 unmapped read", rd, 32'd0);
        check("R8 unmapped latency", 32'(w), 32'd0);
        access(1'b1, 12'h700, 3'd4, 32'hFFFF_FFFF, rd, w);
        access(1'b0, 12'h516, 3'd2, 32'h0, rd, w);
        check("R8 past ext end", rd, 32'd0);
        access(1'b1, 12'h41E, 3'd4, 32'h0, rd, w);
        access(1'b1, 12'h604, 3'd1, 32'h0, rd, w);
        check("R8 no strobes", 32'(bp_n + ix_n), 32'd0);
    endtask

    task automatic t_noloc();
        int w;
        check("R10 rev disabled", 32'(rev2), 32'd0);
        @(negedge clk);
        req_write = 1'b0; req_addr = 12'h600; req_size = 3'd4; req_valid2 = 1'b1;
        #1;
        w = 0;
        while (!req_ready2 && w < 20) begin @(negedge clk); #1; w++; end
        check("R10 disabled read zero", rsp_rdata2, 32'd0);
        check("R10 disabled latency", 32'(w), 32'd0);
        @(negedge clk);
        req_valid2 = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_port_writes();
        t_port_reads();
        t_ext();
        t_local();
        t_unmapped();
        t_noloc();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule